// File: doc/BRIEF.md
# Four-Channel DMA Host Register File

This block is the register side of a four-channel DMA controller as the host CPU sees it. It sits behind a 4-bit I/O port offset with separate read and write strobes and an 8-bit data bus. Each channel keeps a 16-bit base address and a 16-bit base count, plus the current address and current count that the transfer engine works from. Both 16-bit values pass through a single 8-bit port. A shared byte-pointer toggle chooses the low or high byte, and software can force the toggle back to the low byte through a strobe port of its own.

The block also holds a six-bit mode field for each channel, a four-bit channel mask, a command byte and the terminal-count flags. The mask can be written one channel at a time, all at once, or cleared in a single write. The transfer engine outside the block pulses a per-channel step input once for each transfer and presents its pending requests. In return it receives the mask, the command byte and the modes. On each step the register file advances the channel's current address and count, records terminal count, and reloads the channel from its base values when auto-reload is enabled.

Top module: `dma_host_regs`

## Requirements
- R1: After reset the mask output is 4'hF, the command output is 0, all modes are 0, status reads {req_pending, 4'h0}, and every address and count byte reads 0.
- R2: Offsets 0,2,4,6 reach the address of channels 0–3 and offsets 1,3,5,7 their count. Each read or write of offsets 0–7 flips the byte pointer: pointer 0 selects bits 7:0 and pointer 1 selects bits 15:8. A write loads the selected byte into both the base and the current register. A read returns the current register.
- R3: A write of any value to offset 0xC returns the byte pointer to the low byte.
- R4: A write to offset 0xA sets the mask bit of channel wdata[1:0] to wdata[2] (1 = masked).
- R5: A write to offset 0xE clears all four mask bits. A write to offset 0xF loads the mask from wdata[3:0], where bit n belongs to channel n.
- R6: A write to offset 0xB stores wdata[7:2] as the mode of channel wdata[1:0]. mode_out[6n+5:6n] carries channel n's mode, so wdata bit 4 maps to mode index 2 (auto-reload) and wdata bit 5 maps to mode index 3 (address decrement).
- R7: A write to offset 0x8 loads the command byte onto cmd_out. A read of offset 0x8 returns {req_pending[3:0], tc_flags[3:0]}.
- R8: A status read clears the terminal-count flags. A terminal count that occurs in the same cycle as the read stays set.
- R9: A step on a channel whose current count is nonzero lowers that count by one. In the same cycle it raises the current address by one, or lowers it by one when mode index 3 is set.
- R10: A step on a channel whose current count is 0 sets that channel's terminal-count flag. With auto-reload set, the current address and count reload from the base values. Without it, both stay unchanged.
- R11: A write to offset 0xD sets all mask bits and clears the byte pointer, the command byte and the terminal-count flags. Addresses, counts and modes are kept, and a read of 0xD returns 0.
- R12: Writes to offset 0x9 change nothing. Reads of offsets 0x9 and 0xA–0xF return 0 and leave the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_sel | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; side effects take place at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset |
| xfer_step | input | 4 | One pulse per transfer, per channel |
| req_pending | input | 4 | Pending requests, shown in status bits 7:4 |
| chan_mask | output | 4 | Channel mask, 1 = disabled |
| cmd_out | output | 8 | Command byte |
| mode_out | output | 24 | Six mode bits per channel |

## Verification
The hardest case to reach is a terminal count that arrives in the very cycle that software reads and clears the status. The bench drives a step into an exhausted, non-reloading channel and raises the status read strobe in the same clock period. It checks that the sampled byte is still the old status and that the next read shows the new flag. Auto-reload is reached by stepping a one-transfer channel twice in decrement mode. The byte-pointer sequencing is driven into odd states on purpose, first with a lone low-byte write and then with a master clear, before reads confirm that the pointer is back on the low byte.

// File: rtl/dma_host_regs.sv
module dma_host_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  port_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [3:0]  xfer_step,
  input  logic [3:0]  req_pending,
  output logic [3:0]  chan_mask,
  output logic [7:0]  cmd_out,
  output logic [23:0] mode_out
);
  logic [15:0] base_a [4];
  logic [15:0] base_c [4];
  logic [15:0] cur_a  [4];
  logic [15:0] cur_c  [4];
  logic [5:0]  mode   [4];
  logic [3:0]  mask, tc, tc_hit, tc_next;
  logic [7:0]  cmd;
  logic        ptr;
  logic [15:0] rsel;

  wire chan_port = ~port_sel[3];
  wire chan_acc  = (rd_en | wr_en) & chan_port;
  wire stat_rd   = rd_en & (port_sel == 4'h8);
  wire mclr      = wr_en & (port_sel == 4'hD);

  assign chan_mask = mask;
  assign cmd_out   = cmd;

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : g_ch
      assign mode_out[6*g +: 6] = mode[g];
      assign tc_hit[g] = xfer_step[g] & (cur_c[g] == 16'h0);

      AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit[g] && !mode[g][2] && !(wr_en && chan_port && port_sel[2:1] == 2'(g)))
        |=> cur_c[g] == 16'h0); // R10
      AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_hit[g] && !mclr) |=> tc[g]); // R10
    end
  endgenerate

  assign tc_next = mclr ? 4'h0 : ((stat_rd ? 4'h0 : tc) | tc_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= 1'b0;
      mask <= 4'hF;
      cmd  <= 8'h00;
      tc   <= 4'h0;
      for (int i = 0; i < 4; i++) begin
        base_a[i] <= '0;
        base_c[i] <= '0;
        cur_a[i]  <= '0;
        cur_c[i]  <= '0;
        mode[i]   <= '0;
      end
    end else begin
      tc <= tc_next;
      if (chan_acc) ptr <= ~ptr;
      if (wr_en) begin
        case (port_sel)
          4'h8: cmd <= wdata;
          4'hA: mask[wdata[1:0]] <= wdata[2];
          4'hB: mode[wdata[1:0]] <= wdata[7:2];
          4'hC: ptr <= 1'b0;
          4'hD: begin ptr <= 1'b0; cmd <= 8'h00; mask <= 4'hF; end
          4'hE: mask <= 4'h0;
          4'hF: mask <= wdata[3:0];
          default: ;
        endcase
      end
      for (int i = 0; i < 4; i++) begin
        if (xfer_step[i]) begin
          if (cur_c[i] != 16'h0) begin
            cur_c[i] <= cur_c[i] - 16'd1;
            cur_a[i] <= mode[i][3] ? cur_a[i] - 16'd1 : cur_a[i] + 16'd1;
          end else if (mode[i][2]) begin
            cur_a[i] <= base_a[i];
            cur_c[i] <= base_c[i];
          end
        end
        if (wr_en && chan_port && port_sel[2:1] == 2'(i)) begin
          if (!port_sel[0]) begin
            if (ptr) begin base_a[i][15:8] <= wdata; cur_a[i][15:8] <= wdata; end
            else     begin base_a[i][7:0]  <= wdata; cur_a[i][7:0]  <= wdata; end
          end else begin
            if (ptr) begin base_c[i][15:8] <= wdata; cur_c[i][15:8] <= wdata; end
            else     begin base_c[i][7:0]  <= wdata; cur_c[i][7:0]  <= wdata; end
          end
        end
      end
    end
  end

  always_comb begin
    rsel  = port_sel[0] ? cur_c[port_sel[2:1]] : cur_a[port_sel[2:1]];
    rdata = 8'h00;
    if (chan_port)                rdata = ptr ? rsel[15:8] : rsel[7:0];
    else if (port_sel == 4'h8)    rdata = {req_pending, tc};
  end

  AST_PTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_acc |=> ptr != $past(ptr)); // R2
  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && port_sel == 4'hC) |=> !ptr); // R3
  AST_MCLR: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (chan_mask == 4'hF && cmd_out == 8'h00 && !ptr)); // R11
  AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && xfer_step == 4'h0) |=> tc == 4'h0); // R8
  AST_HIGH_PORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && port_sel[3]) |=> $stable(ptr)); // R12
endmodule

// File: tb/dma_host_regs_test.sv
module dma_host_regs_test;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  port_sel = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [3:0]  xfer_step = 0, req_pending = 0;
  logic [3:0]  chan_mask;
  logic [7:0]  cmd_out;
  logic [23:0] mode_out;
  int n_chk = 0, n_bad = 0;
  logic [7:0]  d;

  dma_host_regs uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] v);
    @(negedge clk); port_sel = p; wdata = v; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] p, output logic [7:0] v);
    @(negedge clk); port_sel = p; rd_en = 1;
    #1 v = rdata;
    @(posedge clk); #1 rd_en = 0;
  endtask

  task automatic step(input logic [3:0] s);
    @(negedge clk); xfer_step = s;
    @(posedge clk); #1 xfer_step = 0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 mask", chan_mask, 4'hF);
    chk("R1 cmd", cmd_out, 0);
    chk("R1 mode", mode_out, 0);
    rd(4'h8, d); chk("R1 status", d, 0);
    rd(4'h0, d); chk("R1 addr lo", d, 0);
    rd(4'h0, d); chk("R1 addr hi", d, 0);
  endtask

  task automatic t_load;
    wr(4'hC, 0);
    wr(4'h0, 8'h34); wr(4'h0, 8'h12);
    wr(4'h7, 8'hCD); wr(4'h7, 8'hAB);
    wr(4'h4, 8'h55); wr(4'h4, 8'h66);
    rd(4'h0, d); chk("R2 ch0 addr lo", d, 8'h34);
    rd(4'h0, d); chk("R2 ch0 addr hi", d, 8'h12);
    rd(4'h7, d); chk("R2 ch3 cnt lo", d, 8'hCD);
    rd(4'h7, d); chk("R2 ch3 cnt hi", d, 8'hAB);
    rd(4'h2, d); chk("R2 ch1 addr untouched", d, 0);
    rd(4'h2, d); chk("R2 ch1 addr untouched hi", d, 0);
    rd(4'h4, d); chk("R2 ch2 addr lo", d, 8'h55);
    rd(4'h4, d); chk("R2 ch2 addr hi", d, 8'h66);
  endtask

  task automatic t_ptr_clear;
    wr(4'hC, 0);
    wr(4'h2, 8'h77);
    wr(4'hC, 0);
    wr(4'h2, 8'h88); wr(4'h2, 8'h99);
    rd(4'h2, d); chk("R3 low byte after clear", d, 8'h88);
    rd(4'h2, d); chk("R3 high byte", d, 8'h99);
  endtask

  task automatic t_mask;
    wr(4'hE, 8'hFF); #1 chk("R5 clear all", chan_mask, 4'h0);
    wr(4'hA, 8'h05); #1 chk("R4 mask ch1", chan_mask, 4'h2);
    wr(4'hA, 8'h07); #1 chk("R4 mask ch3", chan_mask, 4'hA);
    wr(4'hA, 8'h01); #1 chk("R4 unmask ch1", chan_mask, 4'h8);
    wr(4'hF, 8'h35); #1 chk("R5 write all", chan_mask, 4'h5);
  endtask

  task automatic t_mode;
    wr(4'hB, 8'h46); #1 chk("R6 ch2 mode", mode_out[17:12], 6'h11);
    wr(4'hB, 8'hC3); #1 chk("R6 ch3 mode", mode_out[23:18], 6'h30);
    chk("R6 ch0 untouched", mode_out[5:0], 0);
  endtask

  task automatic t_cmd;
    wr(4'h8, 8'h5A); #1 chk("R7 cmd", cmd_out, 8'h5A);
    req_pending = 4'h9;
    rd(4'h8, d); chk("R7 status", d, 8'h90);
    req_pending = 0;
  endtask

  task automatic t_step;
    wr(4'hC, 0);
    wr(4'hB, 8'h45);
    wr(4'h2, 8'h00); wr(4'h2, 8'h01);
    wr(4'h3, 8'h02); wr(4'h3, 8'h00);
    step(4'h2); step(4'h2); step(4'h2);
    rd(4'h8, d); chk("R10 tc ch1", d, 8'h02);
    rd(4'h8, d); chk("R8 cleared", d, 8'h00);
    rd(4'h3, d); chk("R10 cnt stays 0 lo", d, 0);
    rd(4'h3, d); chk("R10 cnt stays 0 hi", d, 0);
    rd(4'h2, d); chk("R9 addr incr lo", d, 8'h02);
    rd(4'h2, d); chk("R9 addr incr hi", d, 8'h01);
  endtask

  task automatic t_autoreload;
    wr(4'hB, 8'h74);
    wr(4'h0, 8'h10); wr(4'h0, 8'h00);
    wr(4'h1, 8'h01); wr(4'h1, 8'h00);
    step(4'h1);
    rd(4'h0, d); chk("R9 addr decr lo", d, 8'h0F);
    rd(4'h0, d); chk("R9 addr decr hi", d, 8'h00);
    rd(4'h1, d); chk("R9 cnt decr", d, 8'h00);
    rd(4'h1, d); chk("R9 cnt decr hi", d, 8'h00);
    step(4'h1);
    rd(4'h0, d); chk("R10 reload addr", d, 8'h10);
    rd(4'h0, d); chk("R10 reload addr hi", d, 8'h00);
    rd(4'h1, d); chk("R10 reload cnt", d, 8'h01);
    rd(4'h1, d); chk("R10 reload cnt hi", d, 8'h00);
    rd(4'h8, d); chk("R10 tc ch0", d, 8'h01);
  endtask

  task automatic t_tc_same_cycle;
    wr(4'h7, 8'h00); wr(4'h7, 8'h00);
    rd(4'h8, d);
    @(negedge clk); port_sel = 4'h8; rd_en = 1; xfer_step = 4'h8;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 0; xfer_step = 0;
    chk("R8 old status on same-cycle read", d, 8'h00);
    rd(4'h8, d); chk("R8 new tc survives", d, 8'h08);
    rd(4'h8, d); chk("R8 then cleared", d, 8'h00);
  endtask

  task automatic t_mclr;
    logic [23:0] m;
    m = mode_out;
    wr(4'h8, 8'hFF); wr(4'hE, 0);
    wr(4'h0, 8'hAA);
    step(4'h8);
    wr(4'hD, 0); #1;
    chk("R11 mask set", chan_mask, 4'hF);
    chk("R11 cmd clear", cmd_out, 0);
    chk("R11 mode kept", mode_out, m);
    rd(4'h8, d); chk("R11 tc cleared", d, 0);
    rd(4'h0, d); chk("R11 pointer low", d, 8'hAA);
    rd(4'h0, d); chk("R11 addr kept hi", d, 8'h00);
    rd(4'hD, d); chk("R11 temp reads 0", d, 0);
  endtask

  task automatic t_ignored;
    logic [23:0] m;
    m = mode_out;
    wr(4'h9, 8'hFF); #1;
    chk("R12 mask", chan_mask, 4'hF);
    chk("R12 cmd", cmd_out, 0);
    chk("R12 mode", mode_out, m);
    rd(4'h9, d); chk("R12 read 9", d, 0);
    rd(4'hC, d); chk("R12 read C", d, 0);
    rd(4'hE, d); chk("R12 read E", d, 0);
    rd(4'h0, d); chk("R12 pointer untouched", d, 8'hAA);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_load();
    t_ptr_clear();
    t_mask();
    t_mode();
    t_cmd();
    t_step();
    t_autoreload();
    t_tc_same_cycle();
    t_mclr();
    t_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule